// File: doc/BRIEF.md
# Reset Cause Status Register

This block remembers which event brought the system out of its most recent reset and shows that record as one read-only status byte on a simple CPU bus. A power-on pulse loads a known pattern: its own flag is set and every other flag is cleared. A pulse from any of six further reset sources sets that source's flag and leaves flags that are already set alone. The sources are the external reset pin, the watchdog, an illegal opcode, an opcode fetch from an illegal address, a forced monitor entry and a low-voltage detect.

Software reads the byte once after start-up, and that read clears the whole record. The read data is registered. It shows the value held before the clear and is driven as zero whenever the block is not being read, so it can be ORed into a wider read-data bus. The illegal-address source counts only when the bus reports that the offending access was an opcode fetch.

Top module: `reset_cause_status`

## Requirements
- R1: Register layout: bit 7 power-on, bit 6 external pin (src_i[0]), bit 5 watchdog (src_i[1]), bit 4 illegal opcode (src_i[2]), bit 3 illegal-address fetch (src_i[3]), bit 2 forced monitor entry (src_i[4]), bit 1 low voltage (src_i[5]); bit 0 always reads 0.
- R2: A cycle with por_i high leaves the register at 0x80 and drives rd_data to 0 on the following edge.
- R3: por_i takes priority over a source pulse or a read in the same cycle: the register is 0x80 afterwards.
- R4: A source pulse sets its own flag on the next edge; flags that are already set stay set until a read hit or power-on.
- R5: An illegal-address pulse (src_i[3]) sets bit 3 only while fetch_i is high in the same cycle; with fetch_i low it has no effect.
- R6: A read hit (rd_i high and addr_i equal to CTRL_BASE + STATUS_OFS) puts the pre-clear register value on rd_data one cycle later, and clears all flags on that same edge.
- R7: A source pulse in the same cycle as a read hit does not appear in that read's data, but its flag is set after the edge.
- R8: Without a read hit (no strobe, or another address) rd_data is 0 and no flag is cleared.
- R9: Write strobes (wr_i with any wr_data_i, at any address) change no flag.
- R10: The register answers only at CTRL_BASE + STATUS_OFS; reads at the neighbouring addresses CTRL_BASE and CTRL_BASE + 2 miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset pulse, synchronous, active high |
| src_i | input | NUM_SRC | Reset-source pulses, one bit per non-power-on source |
| fetch_i | input | 1 | Qualifies the illegal-address source as an opcode fetch |
| addr_i | input | ADDR_W | Bus address |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe (ignored by the register) |
| wr_data_i | input | REG_W | Bus write data (ignored) |
| rd_data_o | output | REG_W | Registered read data, 0 when not selected |

## Verification
The bench uses the default parameters: six sources, so the register is eight bits wide, and a 16-bit address with the register at 0xFE01. These defaults fix the bit of every source, so each source can be pulsed alone and its bit checked exactly. Reads at 0xFE00 and 0xFE02 test the address decode. The bench also drives the timing collisions by hand: a read in the same cycle as a source pulse, and a power-on pulse in the same cycle as both.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  // source indices on src_i; the order sets the bit each lands in
  localparam int SRC_PIN      = 0;
  localparam int SRC_WDOG     = 1;
  localparam int SRC_BADOP    = 2;
  localparam int SRC_BADADDR  = 3;
  localparam int SRC_MONITOR  = 4;
  localparam int SRC_LOWVOLT  = 5;

  // bit position of source k in a register of n sources
  function automatic int src_bit(input int k, input int n);
    return n - k;
  endfunction
endpackage

// File: rtl/rcs_capture.sv
module rcs_capture #(
  parameter int NUM_SRC = 6,
  parameter int QUAL_IDX = 3,
  localparam int REG_W = NUM_SRC + 2
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               fetch_i,
  output logic [REG_W-1:0]   set_o
);
  import rcs_pkg::*;

  assign set_o[0]       = 1'b0;
  assign set_o[REG_W-1] = 1'b0;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    if (k == QUAL_IDX) begin : g_qual
      assign set_o[src_bit(k, NUM_SRC)] = src_i[k] & fetch_i;
    end else begin : g_plain
      assign set_o[src_bit(k, NUM_SRC)] = src_i[k];
    end
  end
endmodule

// File: rtl/rcs_flags.sv
module rcs_flags #(
  parameter int NUM_SRC = 6,
  localparam int REG_W = NUM_SRC + 2
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] set_i,
  output logic [REG_W-1:0] flags_o
);
  localparam logic [REG_W-1:0] POR_ONLY = {1'b1, {(REG_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (por_i)      flags_o <= POR_ONLY;
    else if (clr_i) flags_o <= set_i;
    else            flags_o <= flags_o | set_i;
  end

  AST_POR_LOADS: assert property (@(posedge clk) por_i |=> flags_o == POR_ONLY); // R3
  AST_FLAGS_STICK: assert property (@(posedge clk) disable iff (por_i)
    !clr_i |=> (flags_o & $past(flags_o)) == $past(flags_o)); // R4
  AST_SET_LANDS: assert property (@(posedge clk) disable iff (por_i)
    (|set_i) |=> (flags_o & $past(set_i)) == $past(set_i)); // R7
  AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (por_i)
    clr_i |=> (flags_o & ~$past(set_i)) == '0); // R6
endmodule

// File: rtl/rcs_bus.sv
module rcs_bus #(
  parameter int ADDR_W = 16,
  parameter int REG_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE01
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  flags_i,
  output logic              hit_o,
  output logic [REG_W-1:0]  rd_data_o
);
  assign hit_o = rd_i && (addr_i == REG_ADDR);

  always_ff @(posedge clk) begin
    if (por_i)      rd_data_o <= '0;
    else if (hit_o) rd_data_o <= flags_i;
    else            rd_data_o <= '0;
  end

  AST_READ_OLD: assert property (@(posedge clk) disable iff (por_i)
    hit_o |=> rd_data_o == $past(flags_i)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (por_i)
    !hit_o |=> rd_data_o == '0); // R8
  AST_POR_QUIET: assert property (@(posedge clk) por_i |=> rd_data_o == '0); // R2
endmodule

// File: rtl/reset_cause_status.sv
module reset_cause_status #(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 16'hFE00,
  parameter int STATUS_OFS = 1,
  localparam int REG_W = NUM_SRC + 2
) (
  input  logic               clk,
  input  logic               por_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               fetch_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o
);
  import rcs_pkg::*;
  localparam logic [ADDR_W-1:0] REG_ADDR = CTRL_BASE + ADDR_W'(STATUS_OFS);
  localparam int QBIT = NUM_SRC - SRC_BADADDR;

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] flags;
  logic             hit;
  logic             unused_wr;

  assign unused_wr = wr_i ^ (^wr_data_i);

  rcs_capture #(.NUM_SRC(NUM_SRC), .QUAL_IDX(SRC_BADADDR)) i_capture (
    .src_i(src_i), .fetch_i(fetch_i), .set_o(set_vec));

  rcs_flags #(.NUM_SRC(NUM_SRC)) i_flags (
    .clk(clk), .por_i(por_i), .clr_i(hit), .set_i(set_vec), .flags_o(flags));

  rcs_bus #(.ADDR_W(ADDR_W), .REG_W(REG_W), .REG_ADDR(REG_ADDR)) i_bus (
    .clk(clk), .por_i(por_i), .addr_i(addr_i), .rd_i(rd_i),
    .flags_i(flags), .hit_o(hit), .rd_data_o(rd_data_o));

  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (por_i)
    rd_data_o[0] == 1'b0); // R1
  AST_DATA_FETCH_IGNORED: assert property (@(posedge clk) disable iff (por_i)
    (src_i[SRC_BADADDR] && !fetch_i && !hit && !flags[QBIT]) |=> !flags[QBIT]); // R5
  AST_WRITE_INERT: assert property (@(posedge clk) disable iff (por_i)
    (wr_i && !hit && src_i == '0) |=> flags == $past(flags)); // R9
endmodule

// File: tb/test_reset_cause_status.sv
module test_reset_cause_status;
  localparam int NS = 6;
  localparam int RW = 8;
  localparam logic [15:0] RADDR = 16'hFE01;

  logic          clk = 1'b0;
  logic          por_i = 1'b1;
  logic [NS-1:0] src_i = '0;
  logic          fetch_i = 1'b0;
  logic [15:0]   addr_i = '0;
  logic          rd_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [RW-1:0] wr_data_i = '0;
  logic [RW-1:0] rd_data_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  reset_cause_status i_reset_cause_status (
    .clk(clk), .por_i(por_i), .src_i(src_i), .fetch_i(fetch_i),
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o));

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one cycle from a negedge, return at the next negedge with inputs idle
  task automatic step(input logic p, input logic [NS-1:0] s, input logic f,
                      input logic r, input logic w, input logic [15:0] a);
    por_i = p; src_i = s; fetch_i = f; rd_i = r; wr_i = w; addr_i = a;
    wr_data_i = w ? 8'hFF : 8'h00;
    @(negedge clk);
    por_i = 0; src_i = '0; fetch_i = 0; rd_i = 0; wr_i = 0; addr_i = '0; wr_data_i = '0;
  endtask

  task automatic read_chk(input string req, input logic [RW-1:0] exp);
    step(0, '0, 0, 1, 0, RADDR);
    check(req, rd_data_o, exp);
  endtask

  task automatic t_reset();
    step(1, '0, 0, 0, 0, '0);
    check("R2", rd_data_o, 8'h00);
    read_chk("R2", 8'h80);
    read_chk("R6", 8'h00);
  endtask

  task automatic t_each_source();
    for (int k = 0; k < NS; k++) begin
      step(0, NS'(1) << k, 1, 0, 0, '0);
      read_chk("R1", 8'(1) << (NS - k));
    end
  endtask

  task automatic t_sticky();
    step(0, 6'b000001, 0, 0, 0, '0);
    step(0, 6'b000010, 0, 0, 0, '0);
    step(0, 6'b100000, 0, 0, 0, '0);
    read_chk("R4", 8'h62);
  endtask

  task automatic t_illaddr();
    step(0, 6'b001000, 0, 0, 0, '0);
    read_chk("R5", 8'h00);
    step(0, 6'b001000, 1, 0, 0, '0);
    read_chk("R5", 8'h08);
  endtask

  task automatic t_collide();
    step(0, 6'b000010, 0, 0, 0, '0);
    step(0, 6'b000001, 0, 1, 0, RADDR);
    check("R7", rd_data_o, 8'h20);
    read_chk("R7", 8'h40);
  endtask

  task automatic t_miss();
    step(0, 6'b000100, 0, 0, 0, '0);
    step(0, '0, 0, 1, 0, 16'hFE00);
    check("R10", rd_data_o, 8'h00);
    step(0, '0, 0, 1, 0, 16'hFE02);
    check("R10", rd_data_o, 8'h00);
    step(0, '0, 0, 0, 0, RADDR);
    check("R8", rd_data_o, 8'h00);
    read_chk("R8", 8'h10);
  endtask

  task automatic t_write();
    step(0, 6'b100000, 0, 0, 0, '0);
    step(0, '0, 0, 0, 1, RADDR);
    step(0, '0, 0, 0, 1, 16'hFE00);
    read_chk("R9", 8'h02);
  endtask

  task automatic t_por_override();
    step(0, 6'b000001, 0, 0, 0, '0);
    step(1, 6'b111111, 1, 1, 0, RADDR);
    check("R3", rd_data_o, 8'h00);
    read_chk("R3", 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_each_source();
    t_sticky();
    t_illaddr();
    t_collide();
    t_miss();
    t_write();
    t_por_override();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule